// File: doc/BRIEF.md
# Interrupt and Vector Entry Sequencer

This block is the sequential controller that an 8-bit processor with a 16-bit program counter and an 8-bit stack pointer uses to enter and leave exception handlers. It owns five flows: the boot flow after reset, hardware entry for the non-maskable and the maskable request, the software break, and the return from a handler. Every flow is a short chain of byte transfers on a single memory port that uses a valid/ready handshake. The stack lives in the fixed page 0x01. Instruction decode and the arithmetic unit sit outside the block. The surrounding core supplies the current program counter, status byte and stack pointer. It takes back the new values of all three when the block raises its one-cycle completion pulse.

While the sequencer is idle it looks at its requests once per clock and picks at most one. The non-maskable line is edge-sensitive and goes through a pending latch, so a short pulse that arrives while another flow is running is still served afterwards. The maskable line is a level and is honoured only while the interrupt-disable bit of the supplied status is clear. The break and return requests are levels that the core holds until the matching completion pulse. With the completion pulse the block reports the nominal cost of the flow in processor cycles and a code that names the flow.

Top module: `trap_sequencer`

## Requirements
- R1: After the synchronous reset is released, the block reads address 0xFFFC and then 0xFFFD. It then pulses `done` with `done_kind`=0, `pc_out`={byte at 0xFFFD, byte at 0xFFFC}, `sp_out`=0xFF and `p_out`=0x22. While reset is held, `mem_valid` and `done` are low.
- R2: In idle the block serves the first active request in this order: pending non-maskable, maskable (only if `p_in` bit 2 is 0), break, return. A request that is not selected in that cycle starts nothing.
- R3: While `p_in` bit 2 is 1, the maskable level produces no memory transfer and no `done`.
- R4: A rising edge on `nmi_line` sets a pending latch, including while another flow is running. The latch clears when the non-maskable entry starts. A level held high, or a falling edge, does not start a further entry.
- R5: Every entry (non-maskable, maskable, break) writes three bytes, in order, to 0x0100+SP, 0x0100+SP-1 and 0x0100+SP-2 with 8-bit wrap of SP. The bytes are the return PC high byte, the return PC low byte, and the status. The status written is `p_in` with bit 5 set, and bit 4 cleared for hardware entries or set for break.
- R6: After the pushes, an entry reads its vector low byte first: 0xFFFA/0xFFFB for non-maskable, 0xFFFE/0xFFFF for maskable and break. It ends with `pc_out`={high,low} and `sp_out`=SP-3 (8-bit).
- R7: The new status of an entry is the pushed status with bit 3 cleared. Bit 2 is set for maskable and break entries and keeps its `p_in` value for non-maskable entries.
- R8: The break flow pushes `pc_in`+1 as the return address, with a 16-bit carry between the bytes.
- R9: The return flow reads 0x0100+SP+1, +2 and +3 (8-bit wrap) as the status, the PC low byte and the PC high byte. It ends with `p_out`=status OR 0x20, `pc_out`={high,low} and `sp_out`=SP+3.
- R10: `done` is high for exactly one cycle per flow. `done_kind` is 0 for reset, 1 for non-maskable, 2 for maskable, 3 for break and 4 for return. `done_cycles` is 6 for return and 7 for every other flow.
- R11: `mem_valid` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ready`. A transfer takes place at the clock edge where both are high, and read data is taken at that edge. Wait states change neither the order of transfers nor the results.
- R12: `gpr_clear` is high only in the `done` cycle of the reset flow, telling the core to zero its three data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the boot flow on release |
| nmi_line | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_line | input | 1 | Maskable request, level |
| brk_req | input | 1 | Software break request, held until its done |
| rti_req | input | 1 | Return-from-handler request, held until its done |
| pc_in | input | 16 | Current program counter |
| p_in | input | 8 | Current status byte (bit 2 disable, bit 3 decimal, bit 4 break, bit 5 fixed one) |
| sp_in | input | 8 | Current stack pointer |
| mem_valid | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Transfer address |
| mem_wdata | output | 8 | Write data |
| mem_ready | input | 1 | Memory accepts or completes the transfer this cycle |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| done | output | 1 | One-cycle completion pulse |
| done_kind | output | 3 | Flow code, meaningful with done |
| done_cycles | output | 4 | Nominal processor cycles of the flow |
| pc_out | output | 16 | New program counter |
| p_out | output | 8 | New status byte |
| sp_out | output | 8 | New stack pointer |
| gpr_clear | output | 1 | Zero the data registers (reset flow only) |

## Verification
The flows run with status bytes chosen to separate the effects of each bit. The decimal bit is set on input to show that it is cleared. The disable bit is clear and then set to tell the masked case from the honoured case. A pulled status with bit 5 clear and bit 4 set shows the forced bit and the retained break bit. The stack pointers are picked near 0x00 and 0xFF so that the push and pull addresses wrap inside the page. A return address of 0x80FF makes the break increment carry into the high byte. Several requests are raised at once, and a non-maskable pulse is dropped into a running return, to tell the priority order apart from the pending latch. A mode in which the memory inserts wait states shows that only the handshake edges, not the clock count, decide the transfers.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int CW = 4;
    localparam int STEP_W = 3;

    localparam logic [AW-DW-1:0] STACK_PAGE = 'h01;
    localparam logic [AW-1:0] VEC_NMI = 16'hFFFA;
    localparam logic [AW-1:0] VEC_RST = 16'hFFFC;
    localparam logic [AW-1:0] VEC_IRQ = 16'hFFFE;

    localparam logic [CW-1:0] COST_ENTRY = 4'd7;
    localparam logic [CW-1:0] COST_RTI   = 4'd6;

    localparam int FL_I = 2;
    localparam int FL_D = 3;
    localparam int FL_B = 4;
    localparam int FL_U = 5;

    localparam logic [DW-1:0] P_AT_RESET  = 8'h22;
    localparam logic [DW-1:0] SP_AT_RESET = 8'hFF;

    typedef enum logic [2:0] {
        K_RESET = 3'd0,
        K_NMI   = 3'd1,
        K_IRQ   = 3'd2,
        K_BRK   = 3'd3,
        K_RTI   = 3'd4
    } kind_e;

    typedef enum logic [1:0] {D_NONE, D_STAT, D_LO, D_HI} dest_e;

    typedef enum logic [1:0] {S_BOOT, S_IDLE, S_BUSY, S_DONE} state_e;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        dest_e         dest;
        logic          last;
    } step_t;

    function automatic logic [AW-1:0] stack_addr(logic [DW-1:0] sp, logic [DW-1:0] off);
        logic [DW-1:0] s;
        s = sp + off;
        return {STACK_PAGE, s};
    endfunction

    function automatic logic [DW-1:0] push_status(logic [DW-1:0] p, kind_e k);
        logic [DW-1:0] s;
        s = p;
        s[FL_U] = 1'b1;
        s[FL_B] = (k == K_BRK);
        return s;
    endfunction

    function automatic logic [DW-1:0] entry_status(logic [DW-1:0] pushed, kind_e k);
        logic [DW-1:0] s;
        s = pushed;
        s[FL_D] = 1'b0;
        if (k != K_NMI) s[FL_I] = 1'b1;
        return s;
    endfunction

    function automatic logic [CW-1:0] kind_cost(kind_e k);
        return (k == K_RTI) ? COST_RTI : COST_ENTRY;
    endfunction

    function automatic logic is_entry(kind_e k);
        return (k == K_NMI) || (k == K_IRQ) || (k == K_BRK);
    endfunction
endpackage

// File: rtl/trap_nmi_capture.sv
module trap_nmi_capture (
    input  logic clk,
    input  logic rst,
    input  logic nmi_line,
    input  logic take,
    output logic pending
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= nmi_line;
            pending <= 1'b0;
        end else begin
            prev <= nmi_line;
            if (nmi_line && !prev)
                pending <= 1'b1;
            else if (take)
                pending <= 1'b0;
        end
    end

    // R4: without a new edge and without being taken, an empty latch stays empty
    a_r4_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        (!pending && !take && $stable(nmi_line)) |=> !pending);
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic  nmi_pend,
    input  logic  irq_line,
    input  logic  i_mask,
    input  logic  brk_req,
    input  logic  rti_req,
    output logic  go,
    output kind_e pick
);
    always_comb begin
        go   = 1'b1;
        pick = K_NMI;
        if (nmi_pend)
            pick = K_NMI;
        else if (irq_line && !i_mask)
            pick = K_IRQ;
        else if (brk_req)
            pick = K_BRK;
        else if (rti_req)
            pick = K_RTI;
        else
            go = 1'b0;
    end
endmodule

// File: rtl/trap_step_decode.sv
module trap_step_decode
    import trap_pkg::*;
(
    input  kind_e             kind,
    input  logic [STEP_W-1:0] step,
    input  logic [DW-1:0]     sp,
    input  logic [AW-1:0]     ret_pc,
    input  logic [DW-1:0]     stat,
    output step_t             op
);
    logic [AW-1:0] vec;

    always_comb begin
        case (kind)
            K_NMI:   vec = VEC_NMI;
            K_RESET: vec = VEC_RST;
            default: vec = VEC_IRQ;
        endcase

        op.we    = 1'b0;
        op.addr  = vec;
        op.wdata = '0;
        op.dest  = D_NONE;
        op.last  = 1'b0;

        case (kind)
            K_RESET: begin
                op.addr = vec + AW'(step);
                op.dest = (step == 0) ? D_LO : D_HI;
                op.last = (step != 0);
            end
            K_RTI: begin
                op.addr = stack_addr(sp, DW'(step) + DW'(1));
                op.dest = (step == 0) ? D_STAT : ((step == 1) ? D_LO : D_HI);
                op.last = (step == 2);
            end
            default: begin
                if (step < 3) begin
                    op.we    = 1'b1;
                    op.addr  = stack_addr(sp, DW'(0) - DW'(step));
                    op.wdata = (step == 0) ? ret_pc[AW-1:DW] :
                               ((step == 1) ? ret_pc[DW-1:0] : stat);
                end else begin
                    op.addr = vec + AW'(step - STEP_W'(3));
                    op.dest = (step == 3) ? D_LO : D_HI;
                    op.last = (step == 4);
                end
            end
        endcase
    end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import trap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          nmi_line,
    input  logic          irq_line,
    input  logic          brk_req,
    input  logic          rti_req,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] p_in,
    input  logic [DW-1:0] sp_in,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic [2:0]    done_kind,
    output logic [CW-1:0] done_cycles,
    output logic [AW-1:0] pc_out,
    output logic [DW-1:0] p_out,
    output logic [DW-1:0] sp_out,
    output logic          gpr_clear
);
    state_e            state;
    kind_e             kind_q;
    logic [STEP_W-1:0] step_q;
    logic [DW-1:0]     sp_q;
    logic [AW-1:0]     ret_q;
    logic [DW-1:0]     push_q;
    logic [DW-1:0]     stat_q;
    logic [DW-1:0]     lo_q;

    logic  nmi_pend;
    logic  go;
    kind_e pick;
    logic  take_nmi;
    step_t op;

    assign take_nmi = (state == S_IDLE) && go && (pick == K_NMI);

    trap_nmi_capture u_nmi (
        .clk      (clk),
        .rst      (rst),
        .nmi_line (nmi_line),
        .take     (take_nmi),
        .pending  (nmi_pend)
    );

    trap_arbiter u_arb (
        .nmi_pend (nmi_pend),
        .irq_line (irq_line),
        .i_mask   (p_in[FL_I]),
        .brk_req  (brk_req),
        .rti_req  (rti_req),
        .go       (go),
        .pick     (pick)
    );

    trap_step_decode u_dec (
        .kind   (kind_q),
        .step   (step_q),
        .sp     (sp_q),
        .ret_pc (ret_q),
        .stat   (push_q),
        .op     (op)
    );

    assign mem_valid   = (state == S_BUSY);
    assign mem_we      = op.we;
    assign mem_addr    = op.addr;
    assign mem_wdata   = op.wdata;
    assign done        = (state == S_DONE);
    assign done_kind   = kind_q;
    assign done_cycles = kind_cost(kind_q);
    assign gpr_clear   = done && (kind_q == K_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_BOOT;
            kind_q <= K_RESET;
            step_q <= '0;
            sp_q   <= SP_AT_RESET;
            ret_q  <= '0;
            push_q <= '0;
            stat_q <= '0;
            lo_q   <= '0;
            pc_out <= '0;
            p_out  <= P_AT_RESET;
            sp_out <= SP_AT_RESET;
        end else begin
            case (state)
                S_BOOT: begin
                    state <= S_BUSY;
                end
                S_IDLE: begin
                    if (go) begin
                        state  <= S_BUSY;
                        kind_q <= pick;
                        step_q <= '0;
                        sp_q   <= sp_in;
                        ret_q  <= (pick == K_BRK) ? pc_in + AW'(1) : pc_in;
                        push_q <= push_status(p_in, pick);
                    end
                end
                S_BUSY: begin
                    if (mem_ready) begin
                        case (op.dest)
                            D_STAT:  stat_q <= mem_rdata;
                            D_LO:    lo_q   <= mem_rdata;
                            default: ;
                        endcase
                        if (op.last) begin
                            state  <= S_DONE;
                            pc_out <= {mem_rdata, lo_q};
                            case (kind_q)
                                K_RESET: begin
                                    p_out  <= P_AT_RESET;
                                    sp_out <= SP_AT_RESET;
                                end
                                K_RTI: begin
                                    p_out  <= stat_q | (DW'(1) << FL_U);
                                    sp_out <= sp_q + DW'(3);
                                end
                                default: begin
                                    p_out  <= entry_status(push_q, kind_q);
                                    sp_out <= sp_q - DW'(3);
                                end
                            endcase
                        end else begin
                            step_q <= step_q + STEP_W'(1);
                        end
                    end
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end

    // R11: a stalled request keeps its address, direction and data
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                       $stable(mem_we) && $stable(mem_wdata)));

    // R5: writes only ever land in the stack page
    a_r5_write_page: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_we) |-> (mem_addr[AW-1:DW] == STACK_PAGE));

    // R10: completion is a single-cycle pulse
    a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1: boot flow ends with the fixed stack pointer and status
    a_r1_boot_state: assert property (@(posedge clk) disable iff (rst)
        (done && done_kind == K_RESET) |-> (sp_out == SP_AT_RESET &&
                                            p_out == P_AT_RESET && gpr_clear));

    // R9: a returned status always carries bit 5
    a_r9_bit5: assert property (@(posedge clk) disable iff (rst)
        (done && done_kind == K_RTI) |-> p_out[FL_U]);

    // R7: every entry leaves the decimal bit clear
    a_r7_dec_clear: assert property (@(posedge clk) disable iff (rst)
        (done && is_entry(kind_e'(done_kind))) |-> !p_out[FL_D]);

    // R3: a masked maskable request alone starts no transfer
    a_r3_masked: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && irq_line && p_in[FL_I] && !nmi_pend &&
         !brk_req && !rti_req) |=> !mem_valid);

    // R2: a pending non-maskable request wins in idle
    a_r2_nmi_first: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && nmi_pend) |=> (kind_q == K_NMI && mem_valid));
endmodule

// File: tb/sim_trap_sequencer.sv
`timescale 1ns/100ps
module sim_trap_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_line = 1'b0, irq_line = 1'b0, brk_req = 1'b0, rti_req = 1'b0;
    logic [15:0] pc_in = 16'h0;
    logic [7:0]  p_in = 8'h0, sp_in = 8'h0;
    logic        mem_valid, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ready = 1'b0;
    logic [7:0]  mem_rdata = 8'h0;
    logic        done, gpr_clear;
    logic [2:0]  done_kind;
    logic [3:0]  done_cycles;
    logic [15:0] pc_out;
    logic [7:0]  p_out, sp_out;

    always #2.5 clk = ~clk;

    trap_sequencer u0 (
        .clk(clk), .rst(rst), .nmi_line(nmi_line), .irq_line(irq_line),
        .brk_req(brk_req), .rti_req(rti_req), .pc_in(pc_in), .p_in(p_in),
        .sp_in(sp_in), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .done(done), .done_kind(done_kind),
        .done_cycles(done_cycles), .pc_out(pc_out), .p_out(p_out),
        .sp_out(sp_out), .gpr_clear(gpr_clear)
    );

    bit [7:0] ram [0:65535];

    typedef struct {
        bit        we;
        bit [15:0] addr;
        bit [7:0]  data;
        string     tag;
    } xfer_t;

    typedef struct {
        bit [39:0] packed_res;
        string     tag;
    } res_t;

    xfer_t xq[$];
    res_t  rq[$];

    int checks = 0, errors = 0;
    int done_seen = 0, xfer_seen = 0;
    int ready_mode = 0;
    int rcnt = 0;
    bit finished = 0;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void push_x(bit we, bit [15:0] a, bit [7:0] d, string tag);
        xfer_t e;
        e.we = we; e.addr = a; e.data = d; e.tag = tag;
        xq.push_back(e);
    endfunction

    function automatic void push_r(bit [2:0] k, bit [15:0] pc, bit [7:0] p,
                                   bit [7:0] sp, bit [3:0] cyc, bit clr, string tag);
        res_t r;
        r.packed_res = {k, pc, p, sp, cyc, clr};
        r.tag = tag;
        rq.push_back(r);
    endfunction

    // Behavioural model of one entry flow (kind 1 = NMI, 2 = IRQ, 3 = BRK)
    function automatic void exp_entry(int kind, bit [15:0] pc, bit [7:0] p,
                                      bit [7:0] sp, string tag);
        bit [15:0] ret;
        bit [7:0]  pushed, np, s1, s2;
        bit [15:0] vec;
        ret = (kind == 3) ? pc + 16'd1 : pc;
        pushed = p | 8'h20;
        pushed[4] = (kind == 3);
        np = pushed;
        np[3] = 1'b0;
        if (kind != 1) np[2] = 1'b1;
        vec = (kind == 1) ? 16'hFFFA : 16'hFFFE;
        s1 = sp - 8'd1;
        s2 = sp - 8'd2;
        push_x(1, {8'h01, sp}, ret[15:8], tag);
        push_x(1, {8'h01, s1}, ret[7:0], tag);
        push_x(1, {8'h01, s2}, pushed, tag);
        push_x(0, vec, 8'h00, tag);
        push_x(0, vec + 16'd1, 8'h00, tag);
        push_r(3'(kind), {ram[vec + 16'd1], ram[vec]}, np, sp - 8'd3, 4'd7, 1'b0, tag);
    endfunction

    function automatic void exp_rti(bit [7:0] sp, string tag);
        bit [7:0] a1, a2, a3;
        a1 = sp + 8'd1; a2 = sp + 8'd2; a3 = sp + 8'd3;
        push_x(0, {8'h01, a1}, 8'h00, tag);
        push_x(0, {8'h01, a2}, 8'h00, tag);
        push_x(0, {8'h01, a3}, 8'h00, tag);
        push_r(3'd4, {ram[{8'h01, a3}], ram[{8'h01, a2}]}, ram[{8'h01, a1}] | 8'h20,
               a3, 4'd6, 1'b0, tag);
    endfunction

    function automatic void exp_reset(string tag);
        push_x(0, 16'hFFFC, 8'h00, tag);
        push_x(0, 16'hFFFD, 8'h00, tag);
        push_r(3'd0, {ram[16'hFFFD], ram[16'hFFFC]}, 8'h22, 8'hFF, 4'd7, 1'b1, tag);
    endfunction

    // Memory responder and per-clock comparison against the model
    always @(negedge clk) begin
        rcnt++;
        mem_ready = (ready_mode == 0) || (rcnt % 3 == 0);
        mem_rdata = ram[mem_addr];
        if (!rst && mem_valid && mem_ready) begin
            xfer_seen++;
            if (xq.size() == 0) begin
                check(0, "R11", "unexpected transfer", {mem_we, mem_addr, mem_wdata}, 0);
            end else begin
                xfer_t e;
                bit [24:0] act, exp;
                e = xq.pop_front();
                act = {mem_we, mem_addr, mem_wdata};
                exp = {e.we, e.addr, e.we ? e.data : mem_wdata};
                check(act == exp, e.tag, "transfer", act, exp);
            end
            if (mem_we) ram[mem_addr] = mem_wdata;
        end
        if (!rst && gpr_clear && !done)
            check(0, "R12", "gpr_clear outside done", 1, 0);
        if (!rst && done) begin
            done_seen++;
            if (rq.size() == 0) begin
                check(0, "R10", "unexpected done", done_kind, 0);
            end else begin
                res_t r;
                bit [39:0] act;
                r = rq.pop_front();
                act = {done_kind, pc_out, p_out, sp_out, done_cycles, gpr_clear};
                check(act == r.packed_res, r.tag, "kind/pc/p/sp/cycles/clr", act, r.packed_res);
            end
        end
    end

    task automatic step_neg();
        @(negedge clk);
        #0.5;
    endtask

    task automatic wait_drain(string tag);
        int n;
        n = 0;
        while (rq.size() != 0 && n < 3000) begin
            step_neg();
            n++;
        end
        if (rq.size() != 0) check(0, tag, "timeout, results pending", rq.size(), 0);
        check(xq.size() == 0, tag, "transfers left over", xq.size(), 0);
    endtask

    task automatic watch_quiet(int n, string tag);
        int d0, x0;
        d0 = done_seen;
        x0 = xfer_seen;
        for (int i = 0; i < n; i++) step_neg();
        check(done_seen == d0 && xfer_seen == x0, tag, "activity while request ignored",
              (done_seen - d0) + (xfer_seen - x0), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        ram[16'hFFFA] = 8'h00; ram[16'hFFFB] = 8'h90;
        ram[16'hFFFC] = 8'h34; ram[16'hFFFD] = 8'h12;
        ram[16'hFFFE] = 8'hCD; ram[16'hFFFF] = 8'hAB;

        // R1: reset state and boot flow
        repeat (3) step_neg();
        check(mem_valid == 1'b0 && done == 1'b0, "R1", "valid/done in reset",
              {mem_valid, done}, 0);
        exp_reset("R1");
        rst = 1'b0;
        wait_drain("R1");

        // R5 R6 R7 R10: maskable entry, decimal set on input
        pc_in = 16'h4567; p_in = 8'h09; sp_in = 8'hFD;
        exp_entry(2, pc_in, p_in, sp_in, "R5");
        irq_line = 1'b1;
        wait_drain("R6");
        irq_line = 1'b0;

        // R3: masked maskable request is ignored
        p_in = 8'h04;
        irq_line = 1'b1;
        watch_quiet(20, "R3");
        irq_line = 1'b0;

        // R4 R2 R11: NMI pulse during a stalled return, IRQ raised too
        ready_mode = 1;
        p_in = 8'h08; sp_in = 8'hF0;
        ram[16'h01F1] = 8'h10; ram[16'h01F2] = 8'h22; ram[16'h01F3] = 8'h33;
        exp_rti(sp_in, "R9");
        exp_entry(1, pc_in, p_in, sp_in, "R4");
        exp_entry(2, pc_in, p_in, sp_in, "R2");
        rti_req = 1'b1;
        step_neg(); step_neg();
        nmi_line = 1'b1; irq_line = 1'b1;
        step_neg(); step_neg();
        nmi_line = 1'b0;
        wait_drain("R11");
        irq_line = 1'b0; rti_req = 1'b0;
        ready_mode = 0;

        // R4: held level does not re-enter, falling edge does nothing
        p_in = 8'h00; sp_in = 8'hC0; pc_in = 16'h1000;
        exp_entry(1, pc_in, p_in, sp_in, "R4");
        nmi_line = 1'b1;
        wait_drain("R4");
        watch_quiet(20, "R4");
        nmi_line = 1'b0;
        watch_quiet(5, "R4");

        // R8 R5: break with carry and stack wrap below 0x00
        pc_in = 16'h80FF; p_in = 8'h00; sp_in = 8'h01;
        exp_entry(3, pc_in, p_in, sp_in, "R8");
        brk_req = 1'b1;
        wait_drain("R8");
        brk_req = 1'b0;

        // R2: maskable beats break; break not started
        pc_in = 16'h2222; p_in = 8'h08; sp_in = 8'hFF;
        exp_entry(2, pc_in, p_in, sp_in, "R2");
        irq_line = 1'b1; brk_req = 1'b1;
        wait_drain("R2");
        irq_line = 1'b0; brk_req = 1'b0;
        watch_quiet(10, "R2");

        // R9: return with pulled bytes wrapping past 0xFF
        sp_in = 8'hFE;
        ram[16'h01FF] = 8'hC3; ram[16'h0100] = 8'h78; ram[16'h0101] = 8'h56;
        exp_rti(sp_in, "R9");
        rti_req = 1'b1;
        wait_drain("R9");
        rti_req = 1'b0;

        // R11 R8: break again under wait states
        ready_mode = 1;
        pc_in = 16'h3456; p_in = 8'h2C; sp_in = 8'h80;
        exp_entry(3, pc_in, p_in, sp_in, "R11");
        brk_req = 1'b1;
        wait_drain("R11");
        brk_req = 1'b0;
        ready_mode = 0;
        watch_quiet(5, "R10");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule